// File: doc/BRIEF.md
# Circular Delay-Line Address Generator

This block produces physical addresses for an external delay-line RAM used by echo and reverberation effects. Two circular pointers move one location backwards on every audio sample strobe. A tap read picks one pointer and one entry of a 48-entry table of 13-bit offsets. The tap word address is the pointer plus the offset, taken modulo the length of the region that pointer lives in. An offset that is too large for its region is first brought into range, and a flag reports that this happened.

The RAM holds 6144 physical 12-bit locations. A partition mode divides it in one of three ways: one narrow region of 12-bit words, one wide region of 24-bit words, or a narrow region and a wide region side by side. A 24-bit word takes two adjacent physical locations, so wide word addresses are doubled on the way out. The output carries a flag for the word width, so the datapath knows whether to expand a compressed sample. The RAM array and the compress/expand arithmetic are outside this block.

Top module: `dlag_top`

## Requirements
- R1: After reset both pointers are 0, the effective mode is 0, every offset table entry is 0 and `addr_vld` is low.
- R2: A write with `ofs_we` high stores `ofs_wdata` (13 bits) into entry `ofs_waddr` when `ofs_waddr` < 48. Writes to index 48 or above change nothing. A read of index 48 or above uses offset 0.
- R3: When `smp_stb` is high and no mode change is pending, each pointer decrements by one. A pointer at 0 goes to its region length minus 1. Without a strobe the pointers hold.
- R4: Mode encodings on `part_mode` are: 0 = 6144 narrow words; 1 = 3072 wide words; 2 = 4096 narrow words for pointer 0 plus 1024 wide words for pointer 1; 3 behaves as 0. In modes 0, 1 and 3 both pointers run over the same region length.
- R5: A cycle with `rd_req` high gives, on the next cycle, `addr_vld` high with the tap word address (pointer[`ptr_sel`] + reduced offset) mod region length. A cycle without `rd_req` gives `addr_vld` low on the next cycle.
- R6: An offset equal to or larger than the selected region length is reduced modulo that length, and `ofs_wrap` is high for that read. Otherwise `ofs_wrap` is low.
- R7: Narrow accesses set `wide` low, and `phys_addr` equals the word address. Wide accesses set `wide` high, and `phys_addr` is twice the word address. In mode 2, pointer 1 accesses start at physical location 4096.
- R8: When `part_mode` differs from the effective mode, that edge clears both pointers, ignores the strobe and adopts the new mode. Reads in that cycle still use the old mode and old pointers.
- R9: A read in the same cycle as a strobe uses the pointer value from before the decrement. A read of an entry in the same cycle as a write to it uses the old entry value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle audio sample strobe |
| part_mode | input | 2 | Partition mode select |
| ofs_we | input | 1 | Offset table write enable |
| ofs_waddr | input | 6 | Offset table write index |
| ofs_wdata | input | 13 | Offset value to store |
| rd_req | input | 1 | Tap address request |
| tap_idx | input | 6 | Offset table entry for the tap |
| ptr_sel | input | 1 | Pointer (and region) select |
| addr_vld | output | 1 | Address outputs valid |
| phys_addr | output | 13 | Physical 12-bit location address |
| wide | output | 1 | High for a 24-bit word access |
| ofs_wrap | output | 1 | Offset was reduced modulo the region length |

## Verification
Tap reads can coincide with a sample strobe, with a table write, or with a mode change. The bench places a read on the same cycle as each of these, first in directed steps and then in a long pseudo-random run. The run also drives strobes, writes, reads and occasional mode switches together. A behavioural model updates its pointers and table only after it has computed the expected answer for that cycle. A read that wrongly sees the post-strobe pointer, the freshly written entry or the new mode therefore shows up as a mismatch on the next cycle's address.

// File: rtl/dlag_pkg.sv
package dlag_pkg;

  typedef enum logic [1:0] {
    PM_NARROW = 2'd0,
    PM_WIDE   = 2'd1,
    PM_SPLIT  = 2'd2,
    PM_SPARE  = 2'd3
  } part_mode_e;

  localparam int unsigned PHYS_WORDS   = 6144;
  localparam int unsigned SPLIT_NARROW = 4096;
  localparam int unsigned MIN_REGION   = 1024;
  localparam int unsigned LEN_W        = 14;
  localparam int unsigned PHYS_AW      = 13;

  function automatic logic [LEN_W-1:0] region_len(input logic [1:0] m, input logic sel);
    logic [LEN_W-1:0] r;
    case (m)
      PM_WIDE:  r = LEN_W'(PHYS_WORDS / 2);
      PM_SPLIT: r = sel ? LEN_W'((PHYS_WORDS - SPLIT_NARROW) / 2) : LEN_W'(SPLIT_NARROW);
      default:  r = LEN_W'(PHYS_WORDS);
    endcase
    return r;
  endfunction

  function automatic logic region_wide(input logic [1:0] m, input logic sel);
    return (m == PM_WIDE) || ((m == PM_SPLIT) && sel);
  endfunction

  function automatic logic [PHYS_AW-1:0] region_base(input logic [1:0] m, input logic sel);
    return ((m == PM_SPLIT) && sel) ? PHYS_AW'(SPLIT_NARROW) : '0;
  endfunction

endpackage

// File: rtl/dlag_ofs_table.sv
module dlag_ofs_table #(
  parameter int unsigned N     = 48,
  parameter int unsigned W     = 13,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rdata
);

  logic [W-1:0] tbl_q [N];
  logic [W-1:0] tbl_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tbl_d[i] = tbl_q[i];
      if (we && (waddr == IDX_W'(i))) tbl_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tbl_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < N; i++) tbl_q[i] <= tbl_d[i];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (ridx == IDX_W'(i)) rdata = tbl_q[i];
    end
  end

endmodule

// File: rtl/dlag_ptr_unit.sv
module dlag_ptr_unit #(
  parameter int unsigned NPTR  = 2,
  parameter int unsigned LEN_W = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stb,
  input  logic                       clr,
  input  logic [NPTR-1:0][LEN_W-1:0] len,
  output logic [NPTR-1:0][LEN_W-1:0] ptr
);

  logic [NPTR-1:0][LEN_W-1:0] ptr_q;
  logic [NPTR-1:0][LEN_W-1:0] ptr_d;
  logic                       step;

  assign step = stb && !clr;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_comb begin
      if (clr) begin
        ptr_d[g] = '0;
      end else if (ptr_q[g] == '0) begin
        ptr_d[g] = len[g] - LEN_W'(1);
      end else begin
        ptr_d[g] = ptr_q[g] - LEN_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
      end else if (step || clr) begin
        ptr_q[g] <= ptr_d[g];
      end
    end

    // R3
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q[g] < len[g]);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !clr && (ptr_q[g] != '0)) |=> (ptr_q[g] == $past(ptr_q[g]) - LEN_W'(1)));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && !clr) |=> $stable(ptr_q[g]));

    // R8
    ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr_q[g] == '0));
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/dlag_ofs_reduce.sv
module dlag_ofs_reduce #(
  parameter int unsigned OFS_W  = 13,
  parameter int unsigned LEN_W  = 14,
  parameter int unsigned STAGES = 3
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] red,
  output logic             wrapped
);

  localparam int unsigned WW = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + STAGES + 1;

  logic [WW-1:0] chain [STAGES+1];

  assign chain[STAGES] = WW'(ofs);

  for (genvar k = STAGES - 1; k >= 0; k--) begin : g_stage
    logic [WW-1:0] sub_v;
    assign sub_v    = WW'(len) << k;
    assign chain[k] = (chain[k+1] >= sub_v) ? (chain[k+1] - sub_v) : chain[k+1];
  end

  assign red     = chain[0][LEN_W-1:0];
  assign wrapped = WW'(ofs) >= WW'(len);

endmodule

// File: rtl/dlag_top.sv
module dlag_top
  import dlag_pkg::*;
#(
  parameter int unsigned OFS_N = 48,
  parameter int unsigned OFS_W = 13,
  parameter int unsigned IDX_W = $clog2(OFS_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_stb,
  input  logic [1:0]         part_mode,
  input  logic               ofs_we,
  input  logic [IDX_W-1:0]   ofs_waddr,
  input  logic [OFS_W-1:0]   ofs_wdata,
  input  logic               rd_req,
  input  logic [IDX_W-1:0]   tap_idx,
  input  logic               ptr_sel,
  output logic               addr_vld,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic               wide,
  output logic               ofs_wrap
);

  localparam int unsigned NPTR       = 2;
  localparam int unsigned RED_STAGES = $clog2(((2 ** OFS_W) + MIN_REGION - 1) / MIN_REGION);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // effective partition mode
  logic [1:0] mode_q;
  logic       mode_chg;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mode_q <= PM_NARROW;
    else          mode_q <= part_mode;
  end
  assign mode_chg = (part_mode != mode_q);

  // pointers
  logic [NPTR-1:0][LEN_W-1:0] len_vec;
  logic [NPTR-1:0][LEN_W-1:0] ptr_vec;

  for (genvar g = 0; g < NPTR; g++) begin : g_len
    assign len_vec[g] = region_len(mode_q, g[0]);
  end

  dlag_ptr_unit #(
    .NPTR  (NPTR),
    .LEN_W (LEN_W)
  ) u_ptr (
    .clk   (clk),
    .rst_n (rst_i_n),
    .stb   (smp_stb),
    .clr   (mode_chg),
    .len   (len_vec),
    .ptr   (ptr_vec)
  );

  // offset table
  logic [OFS_W-1:0] tap_ofs;

  dlag_ofs_table #(
    .N     (OFS_N),
    .W     (OFS_W),
    .IDX_W (IDX_W)
  ) u_tbl (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (ofs_we),
    .waddr (ofs_waddr),
    .wdata (ofs_wdata),
    .ridx  (tap_idx),
    .rdata (tap_ofs)
  );

  // offset reduction and tap address
  logic [LEN_W-1:0]   rd_len;
  logic [LEN_W-1:0]   rd_ptr;
  logic [LEN_W-1:0]   red_ofs;
  logic               red_wrap;
  logic [LEN_W:0]     sum_w;
  logic [LEN_W-1:0]   word_a;
  logic               wide_d;
  logic [PHYS_AW-1:0] phys_d;

  assign rd_len = region_len(mode_q, ptr_sel);
  assign rd_ptr = ptr_vec[ptr_sel];

  dlag_ofs_reduce #(
    .OFS_W  (OFS_W),
    .LEN_W  (LEN_W),
    .STAGES (RED_STAGES)
  ) u_red (
    .ofs     (tap_ofs),
    .len     (rd_len),
    .red     (red_ofs),
    .wrapped (red_wrap)
  );

  always_comb begin
    sum_w  = {1'b0, rd_ptr} + {1'b0, red_ofs};
    word_a = (sum_w >= {1'b0, rd_len}) ? LEN_W'(sum_w - {1'b0, rd_len}) : LEN_W'(sum_w);
    wide_d = region_wide(mode_q, ptr_sel);
    phys_d = region_base(mode_q, ptr_sel)
           + (wide_d ? PHYS_AW'(word_a << 1) : PHYS_AW'(word_a));
  end

  // output registers
  logic               vld_q;
  logic [PHYS_AW-1:0] phys_q;
  logic               wide_q;
  logic               wrap_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) vld_q <= 1'b0;
    else          vld_q <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      phys_q <= '0;
      wide_q <= 1'b0;
      wrap_q <= 1'b0;
    end else if (rd_req) begin
      phys_q <= phys_d;
      wide_q <= wide_d;
      wrap_q <= red_wrap;
    end
  end

  assign addr_vld  = vld_q;
  assign phys_addr = phys_q;
  assign wide      = wide_q;
  assign ofs_wrap  = wrap_q;

  // R6
  red_range_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_req |-> (red_ofs < rd_len));

  // R7
  phys_range_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    addr_vld |-> (phys_addr < PHYS_AW'(PHYS_WORDS)));

  // R7
  wide_even_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (addr_vld && wide) |-> !phys_addr[0]);

  // R5
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_req |=> addr_vld);

  // R5
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_req |=> !addr_vld);

endmodule

// File: tb/dlag_top_tb_top.sv
`timescale 1ns/1ps
module dlag_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_stb;
  logic [1:0]  part_mode;
  logic        ofs_we;
  logic [5:0]  ofs_waddr;
  logic [12:0] ofs_wdata;
  logic        rd_req;
  logic [5:0]  tap_idx;
  logic        ptr_sel;
  logic        addr_vld;
  logic [12:0] phys_addr;
  logic        wide;
  logic        ofs_wrap;

  always #2.5 clk = ~clk;

  dlag_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .part_mode (part_mode),
    .ofs_we    (ofs_we),
    .ofs_waddr (ofs_waddr),
    .ofs_wdata (ofs_wdata),
    .rd_req    (rd_req),
    .tap_idx   (tap_idx),
    .ptr_sel   (ptr_sel),
    .addr_vld  (addr_vld),
    .phys_addr (phys_addr),
    .wide      (wide),
    .ofs_wrap  (ofs_wrap)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model state
  int mtbl [48];
  int mptr [2];
  int mmode;

  function automatic int mlen(int m, int s);
    if (m == 1) return 3072;
    if (m == 2) return s ? 1024 : 4096;
    return 6144;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit stb, input int m, input bit we, input int wa, input int wd,
                      input bit rd, input int idx, input bit sel, input string tag);
    int o, l, w, e_phys, e_wide, e_wrap;
    smp_stb = stb; part_mode = 2'(m); ofs_we = we; ofs_waddr = 6'(wa);
    ofs_wdata = 13'(wd); rd_req = rd; tap_idx = 6'(idx); ptr_sel = sel;
    o = (idx < 48) ? mtbl[idx] : 0;
    l = mlen(mmode, sel);
    e_wrap = (o >= l);
    w = (mptr[sel] + (o % l)) % l;
    e_wide = (mmode == 1) || (mmode == 2 && sel);
    e_phys = ((mmode == 2 && sel) ? 4096 : 0) + (e_wide ? 2 * w : w);
    if (m != mmode) begin
      mptr[0] = 0; mptr[1] = 0;
    end else if (stb) begin
      for (int i = 0; i < 2; i++) mptr[i] = (mptr[i] == 0) ? mlen(mmode, i) - 1 : mptr[i] - 1;
    end
    mmode = m;
    if (we && wa < 48) mtbl[wa] = wd;
    @(negedge clk);
    chk(tag, "addr_vld", int'(addr_vld), int'(rd));
    if (rd) begin
      chk(tag, "phys_addr", int'(phys_addr), e_phys);
      chk(tag, "wide", int'(wide), e_wide);
      chk(tag, "ofs_wrap", int'(ofs_wrap), e_wrap);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int r, m;
    for (int i = 0; i < 48; i++) mtbl[i] = 0;
    mptr[0] = 0; mptr[1] = 0; mmode = 0;
    rst_n = 1'b0; smp_stb = 0; part_mode = 0; ofs_we = 0; ofs_waddr = 0;
    ofs_wdata = 0; rd_req = 0; tap_idx = 0; ptr_sel = 0;
    repeat (3) @(negedge clk);
    chk("R1", "addr_vld in reset", int'(addr_vld), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 1, 5, 1, "R1");

    // R2: table writes, including out-of-range indices
    step(0, 0, 1, 1, 5, 0, 0, 0, "R2");
    step(0, 0, 1, 2, 6143, 0, 0, 0, "R2");
    step(0, 0, 1, 3, 8191, 0, 0, 0, "R2");
    step(0, 0, 1, 4, 6144, 0, 0, 0, "R2");
    step(0, 0, 1, 47, 100, 0, 0, 0, "R2");
    step(0, 0, 1, 48, 9, 0, 0, 0, "R2");
    step(0, 0, 1, 63, 11, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R5");
    step(0, 0, 0, 0, 0, 1, 2, 0, "R5");
    step(0, 0, 0, 0, 0, 1, 4, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 3, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 47, 1, "R2");
    step(0, 0, 0, 0, 0, 1, 48, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 63, 0, "R2");

    // R3: decrement with wrap from 0
    step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R3");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 0, 1, "R3");

    // R9: read alongside a strobe and alongside a write to the same entry
    step(1, 0, 0, 0, 0, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R9");
    step(0, 0, 1, 1, 77, 1, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R9");

    // R8: mode change with strobe and read in the same cycle
    step(1, 1, 0, 0, 0, 1, 0, 0, "R8");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R8");
    step(0, 1, 0, 0, 0, 1, 2, 0, "R4");
    step(1, 1, 0, 0, 0, 1, 3, 1, "R7");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R7");

    // R4/R7: split mode, pointer 1 wraps at 1024
    step(0, 2, 0, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 1100; i++) step(1, 2, 0, 0, 0, 1, i % 6, i[0], "R4");
    step(0, 2, 0, 0, 0, 1, 3, 1, "R6");
    step(0, 2, 0, 0, 0, 1, 4, 0, "R7");

    // R4: spare encoding behaves as mode 0
    step(0, 3, 0, 0, 0, 1, 0, 0, "R8");
    for (int i = 0; i < 20; i++) step(1, 3, 0, 0, 0, 1, 2, i[0], "R4");

    // mixed pseudo-random run
    seed = 32'h1234_5678;
    m = 3;
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 1103515245 + 12345;
      r = int'(seed >> 8);
      if ((r & 63) == 0) m = (r >> 6) & 3;
      step(r[7], m, r[8] & r[9], (r >> 10) & 63, (r >> 3) & 8191, r[16] | r[17], (r >> 18) & 63,
           r[20], "R9");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule